// File: doc/BRIEF.md
# Stop-Mode Wakeup Stabilization Controller

This controller manages the low-power halt of a small microcontroller. When the core asks to halt, the controller turns off the oscillator enable and gates the core clock. It then waits for a qualifying wake event. A wake event can be a synchronous reset or any wake source whose enable bit was set when the halt began. On wake, the oscillator enable returns at once. The core clock stays gated while an up-counter, paced by a power-of-two prescaler, counts out a settling period for the oscillator.

The settling period is the full range of the counter (2^CNT_W steps) times the prescaler ratio. A wake by one of the enabled sources uses the ratio that was selected by the prescaler code in the last running cycle before the halt. A reset always uses the long ratio 2^RST_DIV_LOG2. With the default parameters this is 256 × 1024 reference cycles. Reset returns the controller to its defaults. An interrupt wake keeps the prescaler code and enable mask it captured.

Top module: `stopwake_ctrl`

## Requirements
- R1: While reset is high and after it falls, the block is settling: `stabilizing`=1, `osc_en`=1, `core_clk_en`=0. Once reset is low, `core_clk_en` rises after exactly 2^CNT_W × 2^RST_DIV_LOG2 clock edges.
- R2: A halt request seen while running drives `osc_en` and `core_clk_en` low from the next cycle. Both stay low, and `stabilizing` stays low, until a wake.
- R3: A halt request is ignored while halted or settling. The settling length and exit are unchanged.
- R4: Wake inputs pass a 2-flop synchronizer. `osc_en` is high in the cycle after the second edge that samples an enabled raw wake bit. `stabilizing` rises one edge later.
- R5: The wake enable mask (bit i enables wake_raw[i]) is captured on the halt-entry edge. A raw wake whose bit was clear then keeps the block halted (`osc_en`=0), even if `wake_en` changes during the halt.
- R6: After an interrupt wake, settling lasts 2^CNT_W × ratio edges. The ratio comes from the prescaler code captured on the halt-entry edge: code c in 0..6 gives 2^(c+1), and code 7 gives 2^RST_DIV_LOG2.
- R7: Changes to `presc_sel` while halted or settling do not change the settling length.
- R8: `stabilizing` is high exactly during settling, and `core_clk_en` is low throughout. `core_clk_en` rises on the cycle after the counter steps past all-ones.
- R9: During settling, further wake events are ignored. A reset during settling restarts the count with the long ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock from the oscillator domain |
| rst | input | 1 | Synchronous active-high reset, also a wake source |
| stop_req | input | 1 | Halt request from the core |
| wake_raw | input | N_WAKE | Asynchronous wake sources (external, watch, serial, key, counter) |
| wake_en | input | N_WAKE | Enable bit per wake source |
| presc_sel | input | 3 | Prescaler code for interrupt-wake settling |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock enable |
| stabilizing | output | 1 | High while the settling count runs |

## Verification
The assertions assume three things about the inputs. A halt request is a single cycle issued while running. Reset is applied from time zero. A settling period is never cut short except by reset. The stimulus drives every input on the falling edge. It pulses `stop_req` for one cycle. It releases raw wake bits only once the block has moved on. It waits a few idle cycles after each return to running before the next halt, so no stale synchronized wake reaches the next halt. Random prescaler codes, masks and sources are mixed with directed resets during halt and during settling.

// File: rtl/stopwake_pkg.sv
`timescale 1ns/1ps
package stopwake_pkg;

    localparam int SEL_W  = 3;
    localparam int LOG2_W = 5;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_HALT = 2'd1,
        PM_SETL = 2'd2
    } pm_state_e;

    typedef struct packed {
        logic              load;
        logic [LOG2_W-1:0] div_log2;
    } settle_cfg_t;

    // code 7 maps to the long ratio; 0..6 map to 2^(code+1)
    function automatic logic [LOG2_W-1:0] code_to_log2(
        input logic [SEL_W-1:0]  code,
        input logic [LOG2_W-1:0] long_log2
    );
        logic [LOG2_W-1:0] res;
        if (code == 3'd7) res = long_log2;
        else              res = {2'b00, code} + 5'd1;
        return res;
    endfunction

endpackage

// File: rtl/stopwake_sync.sv
`timescale 1ns/1ps
module stopwake_sync #(
    parameter int N_WAKE = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_WAKE-1:0] raw_in,
    output logic [N_WAKE-1:0] sync_out
);
    for (genvar gi = 0; gi < N_WAKE; gi++) begin : g_bit
        logic meta_q, stable_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= raw_in[gi];
                stable_q <= meta_q;
            end
        end
        assign sync_out[gi] = stable_q;
    end
endmodule

// File: rtl/stopwake_settle.sv
`timescale 1ns/1ps
module stopwake_settle
    import stopwake_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  settle_cfg_t      cfg,
    input  logic             run_en,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);
    logic [PRE_W-1:0]  pre_q;
    logic [LOG2_W-1:0] div_q;
    logic [PRE_W-1:0]  pre_mask;
    logic              tick;

    assign pre_mask = (PRE_W'(1) << div_q) - PRE_W'(1);
    assign tick     = run_en && (pre_q == pre_mask);
    assign done     = tick && (cnt == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (cfg.load) begin
            pre_q <= '0;
            cnt   <= '0;
            div_q <= cfg.div_log2;
        end else if (run_en) begin
            if (tick) begin
                pre_q <= '0;
                cnt   <= cnt + CNT_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/stopwake_ctrl.sv
`timescale 1ns/1ps
module stopwake_ctrl
    import stopwake_pkg::*;
#(
    parameter int N_WAKE       = 6,
    parameter int CNT_W        = 8,
    parameter int RST_DIV_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_req,
    input  logic [N_WAKE-1:0] wake_raw,
    input  logic [N_WAKE-1:0] wake_en,
    input  logic [SEL_W-1:0]  presc_sel,
    output logic              osc_en,
    output logic              core_clk_en,
    output logic              stabilizing
);
    localparam int PRE_W = (RST_DIV_LOG2 > 7) ? RST_DIV_LOG2 : 7;
    localparam logic [LOG2_W-1:0] LONG_L2 = LOG2_W'(RST_DIV_LOG2);

    pm_state_e         state_q;
    logic [SEL_W-1:0]  code_q;
    logic [N_WAKE-1:0] mask_q;
    logic [N_WAKE-1:0] wake_s;
    logic              wake_hit;
    logic              settle_done;
    logic [CNT_W-1:0]  stab_cnt;
    settle_cfg_t       cfg;

    stopwake_sync #(.N_WAKE(N_WAKE)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (wake_raw),
        .sync_out (wake_s)
    );

    assign wake_hit = (state_q == PM_HALT) && |(wake_s & mask_q);

    always_comb begin
        cfg.load     = rst || wake_hit;
        cfg.div_log2 = rst ? LONG_L2 : code_to_log2(code_q, LONG_L2);
    end

    stopwake_settle #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_settle (
        .clk    (clk),
        .cfg    (cfg),
        .run_en (state_q == PM_SETL),
        .cnt    (stab_cnt),
        .done   (settle_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PM_SETL;
            code_q  <= 3'd7;
            mask_q  <= '0;
        end else begin
            unique case (state_q)
                PM_RUN: begin
                    code_q <= presc_sel;
                    if (stop_req) begin
                        state_q <= PM_HALT;
                        mask_q  <= wake_en;
                    end
                end
                PM_HALT: if (wake_hit)    state_q <= PM_SETL;
                PM_SETL: if (settle_done) state_q <= PM_RUN;
                default:                  state_q <= PM_RUN;
            endcase
        end
    end

    assign osc_en      = (state_q != PM_HALT) || wake_hit;
    assign core_clk_en = (state_q == PM_RUN);
    assign stabilizing = (state_q == PM_SETL);
endmodule

// File: rtl/stopwake_chk.sv
`timescale 1ns/1ps
module stopwake_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             stop_req,
    input logic             osc_en,
    input logic             core_clk_en,
    input logic             stabilizing,
    input logic [CNT_W-1:0] cnt
);
    assert_stop_gates_R2: assert property (@(posedge clk) disable iff (rst)
        (core_clk_en && stop_req) |=> (!osc_en && !core_clk_en));

    assert_halt_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (stabilizing && stop_req) |=> (stabilizing || core_clk_en));

    assert_wake_to_settle_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_en) |=> stabilizing);

    assert_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        stabilizing |-> (osc_en && !core_clk_en));

    assert_count_up_R6: assert property (@(posedge clk) disable iff (rst)
        (stabilizing && $past(stabilizing)) |-> (cnt >= $past(cnt)));

    assert_full_count_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(stabilizing) && core_clk_en) |-> ($past(cnt) == {CNT_W{1'b1}}));
endmodule

bind stopwake_ctrl stopwake_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stop_req    (stop_req),
    .osc_en      (osc_en),
    .core_clk_en (core_clk_en),
    .stabilizing (stabilizing),
    .cnt         (stab_cnt)
);

// File: tb/test_stopwake_ctrl.sv
`timescale 1ns/1ps
module test_stopwake_ctrl;
    localparam int NW    = 6;
    localparam int CW    = 4;
    localparam int RL2   = 4;
    localparam int STEPS = 1 << CW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stop_req = 1'b0;
    logic [NW-1:0] wake_raw = '0;
    logic [NW-1:0] wake_en = '0;
    logic [2:0]    presc_sel = 3'd0;
    logic          osc_en, core_clk_en, stabilizing;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    stopwake_ctrl #(.N_WAKE(NW), .CNT_W(CW), .RST_DIV_LOG2(RL2)) i_stopwake_ctrl (
        .clk(clk), .rst(rst), .stop_req(stop_req), .wake_raw(wake_raw),
        .wake_en(wake_en), .presc_sel(presc_sel), .osc_en(osc_en),
        .core_clk_en(core_clk_en), .stabilizing(stabilizing)
    );

    function automatic int exp_settle(input logic [2:0] code);
        int ratio;
        ratio = (code == 3'd7) ? (1 << RL2) : (2 << code);
        return STEPS * ratio;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_until_core(output int n, output bit bad);
        bad = 1'b0;
        n = 0;
        while (!core_clk_en && n < 20000) begin
            if (!stabilizing || !osc_en) bad = 1'b1;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic apply_reset(input string tag);
        int n;
        bit bad;
        @(negedge clk);
        rst = 1'b1;
        stop_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(stabilizing && osc_en && !core_clk_en, {tag, " R1 state in reset"},
            {29'd0, stabilizing, osc_en, core_clk_en}, 6);
        rst = 1'b0;
        run_until_core(n, bad);
        chk(n == exp_settle(3'd7), {tag, " R1 reset settle length"}, n, exp_settle(3'd7));
        chk(!bad && !stabilizing, {tag, " R8 frozen during reset settle"}, int'(bad), 0);
    endtask

    task automatic enter_halt(input logic [2:0] code, input logic [NW-1:0] mask);
        @(negedge clk);
        presc_sel = code;
        wake_en = mask;
        repeat (3) @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        chk(!osc_en && !core_clk_en && !stabilizing, "R2 halted after request",
            {29'd0, osc_en, core_clk_en, stabilizing}, 0);
        presc_sel = 3'($urandom);   // R7: ignored while halted
        wake_en = NW'($urandom);    // R5: ignored after capture
    endtask

    task automatic wake_measure(input int src, input int exp_d, input bit disturb);
        int n;
        bit bad;
        wake_raw[src] = 1'b1;
        @(negedge clk);
        chk(!osc_en, "R4 no wake after one sync stage", int'(osc_en), 0);
        @(negedge clk);
        chk(osc_en && !stabilizing, "R4 osc_en on detection cycle",
            {30'd0, osc_en, stabilizing}, 2);
        wake_raw[src] = 1'b0;
        @(negedge clk);
        chk(stabilizing && !core_clk_en, "R8 settle entered", int'(stabilizing), 1);
        presc_sel = 3'($urandom);   // R7
        if (disturb) begin
            wake_raw = '1;          // R9: wakes while settling
            stop_req = 1'b1;        // R3: halt while settling
            @(negedge clk);
            stop_req = 1'b0;
            @(negedge clk);
            wake_raw = '0;
            run_until_core(n, bad);
            n = n + 5;
        end else begin
            run_until_core(n, bad);
            n = n + 3;
        end
        chk(n == 3 + exp_d, disturb ? "R6 R9 R3 settle length" : "R6 settle length",
            n, 3 + exp_d);
        chk(!bad && !stabilizing, "R8 stabilizing exactly during settle", int'(bad), 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int pick;
        logic [2:0]    code;
        logic [NW-1:0] mask;
        int src;

        // R1: power-up reset
        apply_reset("power-up");

        // directed: smallest and long ratio, interrupt wake
        enter_halt(3'd0, 6'b000001);
        wake_measure(0, exp_settle(3'd0), 1'b0);
        enter_halt(3'd7, 6'b100000);
        wake_measure(5, exp_settle(3'd7), 1'b1);

        // R5: disabled source ignored, then enabled one wakes
        enter_halt(3'd2, 6'b000100);
        wake_en = '1;
        wake_raw[1] = 1'b1;
        repeat (8) @(negedge clk);
        chk(!osc_en && !core_clk_en, "R5 disabled source ignored", int'(osc_en), 0);
        wake_raw[1] = 1'b0;
        repeat (3) @(negedge clk);
        wake_measure(2, exp_settle(3'd2), 1'b0);

        // R3: halt request while halted
        enter_halt(3'd3, 6'b001000);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        wake_measure(3, exp_settle(3'd3), 1'b0);

        // R1: reset wake from halt
        enter_halt(3'd1, 6'b000000);
        apply_reset("reset from halt");

        // R9: reset during settle restarts with long ratio
        enter_halt(3'd6, 6'b010000);
        wake_raw[4] = 1'b1;
        repeat (3) @(negedge clk);
        wake_raw[4] = 1'b0;
        repeat (100) @(negedge clk);
        chk(stabilizing, "R9 still settling before reset", int'(stabilizing), 1);
        apply_reset("R9 reset during settle");

        // constrained random
        for (int it = 0; it < 24; it++) begin
            code = 3'($urandom);
            mask = NW'($urandom);
            src = int'($urandom % NW);
            pick = int'($urandom % 2);
            enter_halt(code, mask);
            if (mask[src]) begin
                wake_measure(src, exp_settle(code), bit'(pick));
            end else begin
                wake_raw[src] = 1'b1;
                repeat (6) @(negedge clk);
                chk(!osc_en && !core_clk_en, "R5 random disabled source", int'(osc_en), 0);
                wake_raw[src] = 1'b0;
                repeat (3) @(negedge clk);
                if (mask != '0) begin
                    for (int b = NW - 1; b >= 0; b--)
                        if (mask[b]) src = b;
                    wake_measure(src, exp_settle(code), 1'b0);
                end else begin
                    apply_reset("R1 random reset wake");
                end
            end
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule